// File: doc/BRIEF.md
# Embedded Display Panel Power Sequencer

This block drives the three supply and enable outputs of an embedded display panel (power rail, video, backlight) in a fixed order. A programmable minimum delay separates each step. Software holds a single power-target level. On a rising target the block raises the rail, waits for the panel to boot, allows auxiliary-channel traffic and link training, turns video on, waits for training to complete, and finally turns the backlight on. On a falling target it runs the reverse sequence. After the rail drops, it enforces a power-cycle window during which the panel cannot be powered again.

Each interval takes the larger of two configuration sources: a register field and a table value. A table value of zero therefore leaves the register value in force. The register cycle field is counted in coarse units and multiplied by `CYC_SCALE` into tick units before the comparison. A free-running prescaler turns the system clock into a tick, nominally 100 µs, and every delay counter counts these ticks.

A force-rail request powers only the rail and the auxiliary channel so that the sink can be queried while the panel is dark. Status outputs report the following:
- panel-on
- a two-bit sequence state
- busy
- cycle-window active
- a sticky flag for a power-down that took too long

Top module: `panel_pwr_seq`

## Requirements
- R1: After `rail_en_o` rises in a power-up, `aux_ready_o` stays low for the up delay (D_up ticks, within one tick of granularity) before rising. `aux_ready_o` is never high without `rail_en_o`.
- R2: `backlight_en_o` rises no earlier than D_blon ticks after `video_en_o` rises, and only after `train_done_i` has been seen high. It is never high without `video_en_o`.
- R3: On power-down, `backlight_en_o` falls first. `video_en_o` stays high for D_bloff ticks afterwards and then falls.
- R4: After `video_en_o` falls, `rail_en_o` stays high for D_down ticks before it falls (unless force-rail is held).
- R5: When the rail is removed, `cycle_active_o` is high for D_cyc ticks. During that window `rail_en_o` stays low even with the target high.
- R6: Each D value is max(register field, table field). For the cycle interval the register field is first multiplied by `CYC_SCALE`.
- R7: With the target low and no cycle window running, `force_vdd_i` raises `rail_en_o` alone. `aux_ready_o` follows after D_up ticks. A later power-up from this state skips the up delay. A power-down with force-rail held keeps the rail and aux up with no cycle window. Releasing force-rail drops the rail and opens the cycle window.
- R8: The enable order is rail, aux ready with `link_train_o`, `video_en_o`, training done, backlight. The disable order is backlight, video with link, rail.
- R9: If the idle-off condition is not reached within `TIMEOUT_TICKS` ticks of a power-down start, `timeout_o` is set. The idle-off condition is panel-on low, off-idle state and no cycle window. The flag stays set until the next power-up starts.
- R10: `seq_state_o` encodes 00 off-idle, 01 powering-up, 10 on-idle, 11 powering-down. The cycle window reports 00 with `busy_o` high. In on-idle, `panel_on_o` is high and `busy_o` is low.
- R11: A target change during a sequence does not alter it. The sequence completes, and the target level present at the next idle state starts the next sequence.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_target_i | input | 1 | Requested panel power level |
| force_vdd_i | input | 1 | Request rail and aux only |
| train_done_i | input | 1 | Link training complete handshake |
| cfg_up_dly_i | input | REG_W | Register up delay, ticks |
| cfg_blon_dly_i | input | REG_W | Register backlight-on delay, ticks |
| cfg_bloff_dly_i | input | REG_W | Register backlight-off delay, ticks |
| cfg_down_dly_i | input | REG_W | Register video-off-to-rail-off delay, ticks |
| cfg_cycle_i | input | CYC_W | Register cycle delay, coarse units |
| tbl_up_dly_i | input | CNT_W | Table up delay, ticks |
| tbl_blon_dly_i | input | CNT_W | Table backlight-on delay, ticks |
| tbl_bloff_dly_i | input | CNT_W | Table backlight-off delay, ticks |
| tbl_down_dly_i | input | CNT_W | Table down delay, ticks |
| tbl_cycle_i | input | CNT_W | Table cycle delay, ticks |
| rail_en_o | output | 1 | Panel power rail enable |
| aux_ready_o | output | 1 | Auxiliary channel may be used |
| link_train_o | output | 1 | Link training start / link up |
| video_en_o | output | 1 | Video valid |
| backlight_en_o | output | 1 | Backlight enable |
| panel_on_o | output | 1 | Panel powered status |
| seq_state_o | output | 2 | Sequence state code |
| busy_o | output | 1 | A timed step or cycle window is running |
| cycle_active_o | output | 1 | Power-cycle window active |
| timeout_o | output | 1 | Sticky power-down timeout flag |

## Verification
The assertions assume that the configuration inputs are static while a sequence is running. The delay selector registers them once and the counters load that snapshot at each step. They also assume that `train_done_i` is a level that stays high once training has finished. The stimulus changes configuration only after the cycle window has closed, and it waits a few clocks before raising the target. It holds `train_done_i` steady except in the one test that withholds it to show the backlight waiting. Delay sweeps use values three ticks apart, so the one-tick granularity window of each measured interval cannot be mistaken for a neighbouring value.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int NUM_DLY = 5;
  localparam int D_UP    = 0;
  localparam int D_BLON  = 1;
  localparam int D_BLOFF = 2;
  localparam int D_DOWN  = 3;
  localparam int D_CYC   = 4;

  typedef enum logic [3:0] {
    S_OFF, S_VDD_WAIT, S_VDD_ON, S_UP_RAIL, S_UP_LINK, S_UP_PANEL,
    S_UP_BL, S_ON, S_DN_BL, S_DN_VID, S_CYCLE
  } pps_state_e;

  typedef enum logic [1:0] {
    SEQ_OFF_IDLE = 2'b00,
    SEQ_UP       = 2'b01,
    SEQ_ON_IDLE  = 2'b10,
    SEQ_DOWN     = 2'b11
  } seq_code_e;

  typedef struct packed {
    logic      rail;
    logic      aux;
    logic      link;
    logic      video;
    logic      bl;
    logic      pwr_on;
    logic      busy;
    logic      cyc;
    seq_code_e seq;
  } pps_out_t;

  function automatic pps_out_t pps_decode(pps_state_e s);
    pps_out_t o;
    o = '{rail: 1'b0, aux: 1'b0, link: 1'b0, video: 1'b0, bl: 1'b0,
          pwr_on: 1'b0, busy: 1'b0, cyc: 1'b0, seq: SEQ_OFF_IDLE};
    case (s)
      S_VDD_WAIT: begin o.rail = 1'b1; o.busy = 1'b1; end
      S_VDD_ON:   begin o.rail = 1'b1; o.aux = 1'b1; end
      S_UP_RAIL:  begin o.rail = 1'b1; o.busy = 1'b1; o.seq = SEQ_UP; end
      S_UP_LINK:  begin o.rail = 1'b1; o.aux = 1'b1; o.link = 1'b1;
                        o.busy = 1'b1; o.seq = SEQ_UP; end
      S_UP_PANEL, S_UP_BL: begin
                        o.rail = 1'b1; o.aux = 1'b1; o.link = 1'b1;
                        o.video = 1'b1; o.busy = 1'b1; o.seq = SEQ_UP; end
      S_ON:       begin o.rail = 1'b1; o.aux = 1'b1; o.link = 1'b1;
                        o.video = 1'b1; o.bl = 1'b1; o.pwr_on = 1'b1;
                        o.seq = SEQ_ON_IDLE; end
      S_DN_BL:    begin o.rail = 1'b1; o.aux = 1'b1; o.link = 1'b1;
                        o.video = 1'b1; o.pwr_on = 1'b1; o.busy = 1'b1;
                        o.seq = SEQ_DOWN; end
      S_DN_VID:   begin o.rail = 1'b1; o.aux = 1'b1; o.pwr_on = 1'b1;
                        o.busy = 1'b1; o.seq = SEQ_DOWN; end
      S_CYCLE:    begin o.cyc = 1'b1; o.busy = 1'b1; end
      default:    ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pps_tick.sv
module pps_tick #(
  parameter int DIV = 20000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pps_delay_sel.sv
module pps_delay_sel
  import pps_pkg::*;
#(
  parameter int REG_W     = 13,
  parameter int CYC_W     = 4,
  parameter int CNT_W     = 16,
  parameter int CYC_SCALE = 1000
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [D_CYC-1:0][REG_W-1:0]       reg_dly,
  input  logic [CYC_W-1:0]                  reg_cyc,
  input  logic [NUM_DLY-1:0][CNT_W-1:0]     tbl_dly,
  output logic [NUM_DLY-1:0][CNT_W-1:0]     dly
);
  localparam logic [CNT_W-1:0] SCALE = CNT_W'(CYC_SCALE);

  for (genvar i = 0; i < NUM_DLY; i++) begin : g_ch
    logic [CNT_W-1:0] reg_ticks;
    logic [CNT_W-1:0] pick_q;
    if (i == D_CYC) begin : g_scaled
      assign reg_ticks = CNT_W'(reg_cyc) * SCALE;
    end else begin : g_plain
      assign reg_ticks = CNT_W'(reg_dly[i]);
    end
    always_ff @(posedge clk) begin
      if (rst) pick_q <= '0;
      else     pick_q <= (reg_ticks > tbl_dly[i]) ? reg_ticks : tbl_dly[i];
    end
    assign dly[i] = pick_q;
  end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int TIMEOUT_TICKS = 50000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  logic                          tgt,
  input  logic                          force_vdd,
  input  logic                          train_done,
  input  logic [NUM_DLY-1:0][CNT_W-1:0] dly,
  output pps_out_t                      o,
  output logic                          timeout
);
  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_TICKS);

  pps_state_e       state, state_n;
  logic [CNT_W-1:0] cnt, ld_val;
  logic             load, done;
  logic [TW-1:0]    tcnt;
  logic             tarm;
  logic             down_start, idle_off, up_start;

  assign done = (cnt == '0);

  always_comb begin
    state_n = state;
    load    = 1'b0;
    ld_val  = '0;
    case (state)
      S_OFF:
        if (tgt) begin
          state_n = S_UP_RAIL; load = 1'b1; ld_val = dly[D_UP];
        end else if (force_vdd) begin
          state_n = S_VDD_WAIT; load = 1'b1; ld_val = dly[D_UP];
        end
      S_VDD_WAIT: if (done) state_n = S_VDD_ON;
      S_VDD_ON:
        if (tgt) state_n = S_UP_LINK;
        else if (!force_vdd) begin
          state_n = S_CYCLE; load = 1'b1; ld_val = dly[D_CYC];
        end
      S_UP_RAIL:  if (done) state_n = S_UP_LINK;
      S_UP_LINK:  state_n = S_UP_PANEL;
      S_UP_PANEL:
        if (train_done) begin
          state_n = S_UP_BL; load = 1'b1; ld_val = dly[D_BLON];
        end
      S_UP_BL:    if (done) state_n = S_ON;
      S_ON:
        if (!tgt) begin
          state_n = S_DN_BL; load = 1'b1; ld_val = dly[D_BLOFF];
        end
      S_DN_BL:
        if (done) begin
          state_n = S_DN_VID; load = 1'b1; ld_val = dly[D_DOWN];
        end
      S_DN_VID:
        if (done) begin
          if (force_vdd) state_n = S_VDD_ON;
          else begin
            state_n = S_CYCLE; load = 1'b1; ld_val = dly[D_CYC];
          end
        end
      S_CYCLE:    if (done) state_n = S_OFF;
      default:    state_n = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_OFF;
      cnt   <= '0;
      o     <= pps_decode(S_OFF);
    end else begin
      state <= state_n;
      o     <= pps_decode(state_n);
      if (load)                cnt <= ld_val;
      else if (tick && !done)  cnt <= cnt - 1'b1;
    end
  end

  // power-down watchdog
  assign down_start = (state == S_ON) && (state_n == S_DN_BL);
  assign idle_off   = (state_n == S_OFF) || (state_n == S_VDD_ON);
  assign up_start   = (state_n == S_UP_RAIL) ||
                      ((state == S_VDD_ON) && (state_n == S_UP_LINK));

  always_ff @(posedge clk) begin
    if (rst) begin
      tarm    <= 1'b0;
      tcnt    <= '0;
      timeout <= 1'b0;
    end else begin
      if (up_start) timeout <= 1'b0;
      if (down_start) begin
        tarm <= 1'b1;
        tcnt <= '0;
      end else if (tarm) begin
        if (idle_off) tarm <= 1'b0;
        else if (tick && tcnt != TLIM) tcnt <= tcnt + 1'b1;
        if (tcnt == TLIM) timeout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int TICK_DIV      = 20000,
  parameter int REG_W         = 13,
  parameter int CYC_W         = 4,
  parameter int CNT_W         = 16,
  parameter int CYC_SCALE     = 1000,
  parameter int TIMEOUT_TICKS = 50000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_target_i,
  input  logic             force_vdd_i,
  input  logic             train_done_i,
  input  logic [REG_W-1:0] cfg_up_dly_i,
  input  logic [REG_W-1:0] cfg_blon_dly_i,
  input  logic [REG_W-1:0] cfg_bloff_dly_i,
  input  logic [REG_W-1:0] cfg_down_dly_i,
  input  logic [CYC_W-1:0] cfg_cycle_i,
  input  logic [CNT_W-1:0] tbl_up_dly_i,
  input  logic [CNT_W-1:0] tbl_blon_dly_i,
  input  logic [CNT_W-1:0] tbl_bloff_dly_i,
  input  logic [CNT_W-1:0] tbl_down_dly_i,
  input  logic [CNT_W-1:0] tbl_cycle_i,
  output logic             rail_en_o,
  output logic             aux_ready_o,
  output logic             link_train_o,
  output logic             video_en_o,
  output logic             backlight_en_o,
  output logic             panel_on_o,
  output logic [1:0]       seq_state_o,
  output logic             busy_o,
  output logic             cycle_active_o,
  output logic             timeout_o
);
  logic                          tick;
  logic [D_CYC-1:0][REG_W-1:0]   reg_pack;
  logic [NUM_DLY-1:0][CNT_W-1:0] tbl_pack;
  logic [NUM_DLY-1:0][CNT_W-1:0] dly;
  pps_out_t                      st;

  assign reg_pack = {cfg_down_dly_i, cfg_bloff_dly_i, cfg_blon_dly_i, cfg_up_dly_i};
  assign tbl_pack = {tbl_cycle_i, tbl_down_dly_i, tbl_bloff_dly_i,
                     tbl_blon_dly_i, tbl_up_dly_i};

  pps_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  pps_delay_sel #(
    .REG_W(REG_W), .CYC_W(CYC_W), .CNT_W(CNT_W), .CYC_SCALE(CYC_SCALE)
  ) u_sel (
    .clk(clk), .rst(rst), .reg_dly(reg_pack), .reg_cyc(cfg_cycle_i),
    .tbl_dly(tbl_pack), .dly(dly)
  );

  pps_fsm #(.CNT_W(CNT_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .tgt(pwr_target_i),
    .force_vdd(force_vdd_i), .train_done(train_done_i), .dly(dly),
    .o(st), .timeout(timeout_o)
  );

  assign rail_en_o      = st.rail;
  assign aux_ready_o    = st.aux;
  assign link_train_o   = st.link;
  assign video_en_o     = st.video;
  assign backlight_en_o = st.bl;
  assign panel_on_o     = st.pwr_on;
  assign seq_state_o    = st.seq;
  assign busy_o         = st.busy;
  assign cycle_active_o = st.cyc;
endmodule

// File: rtl/pps_chk.sv
module pps_chk (
  input logic       clk,
  input logic       rst,
  input logic       rail_en_o,
  input logic       aux_ready_o,
  input logic       link_train_o,
  input logic       video_en_o,
  input logic       backlight_en_o,
  input logic       panel_on_o,
  input logic [1:0] seq_state_o,
  input logic       busy_o,
  input logic       cycle_active_o
);
  AST_AUX_NEEDS_RAIL: assert property (@(posedge clk) disable iff (rst)
    aux_ready_o |-> rail_en_o); // R1
  AST_BL_NEEDS_VIDEO: assert property (@(posedge clk) disable iff (rst)
    backlight_en_o |-> video_en_o); // R2
  AST_BL_RISE_AFTER_VIDEO: assert property (@(posedge clk) disable iff (rst)
    $rose(backlight_en_o) |-> $past(video_en_o)); // R2
  AST_VIDEO_OUTLIVES_BL: assert property (@(posedge clk) disable iff (rst)
    $fell(backlight_en_o) |-> video_en_o); // R3
  AST_RAIL_OUTLIVES_VIDEO: assert property (@(posedge clk) disable iff (rst)
    $fell(video_en_o) |-> rail_en_o); // R4
  AST_NO_RAIL_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cycle_active_o |-> !rail_en_o); // R5
  AST_RAIL_DROP_OPENS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rail_en_o) |-> cycle_active_o); // R5
  AST_RAIL_RISE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_en_o) |-> !$past(cycle_active_o)); // R5
  AST_VIDEO_NEEDS_LINK_UP: assert property (@(posedge clk) disable iff (rst)
    video_en_o |-> (aux_ready_o && link_train_o)); // R8
  AST_ON_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
    (seq_state_o == 2'b10) |-> (backlight_en_o && panel_on_o && !busy_o)); // R10
endmodule

bind panel_pwr_seq pps_chk u_chk (
  .clk(clk), .rst(rst), .rail_en_o(rail_en_o), .aux_ready_o(aux_ready_o),
  .link_train_o(link_train_o), .video_en_o(video_en_o),
  .backlight_en_o(backlight_en_o), .panel_on_o(panel_on_o),
  .seq_state_o(seq_state_o), .busy_o(busy_o), .cycle_active_o(cycle_active_o)
);

// File: tb/sim_panel_pwr_seq.sv
`timescale 1ns/1ps
module sim_panel_pwr_seq;
  localparam int DIV   = 4;
  localparam int SCALE = 6;
  localparam int TMO   = 30;

  logic clk = 1'b0, rst = 1'b1;
  logic tgt = 1'b0, fvdd = 1'b0, tdone = 1'b1;
  logic [12:0] c_up = '0, c_blon = '0, c_bloff = '0, c_dn = '0;
  logic [3:0]  c_cyc = '0;
  logic [15:0] t_up = '0, t_blon = '0, t_bloff = '0, t_dn = '0, t_cyc = '0;
  logic rail, aux, link, video, bl, pon, busy, cact, tmo;
  logic [1:0] seq;

  always #2.5 clk = ~clk;

  panel_pwr_seq #(.TICK_DIV(DIV), .CYC_SCALE(SCALE), .TIMEOUT_TICKS(TMO)) u0 (
    .clk(clk), .rst(rst), .pwr_target_i(tgt), .force_vdd_i(fvdd),
    .train_done_i(tdone), .cfg_up_dly_i(c_up), .cfg_blon_dly_i(c_blon),
    .cfg_bloff_dly_i(c_bloff), .cfg_down_dly_i(c_dn), .cfg_cycle_i(c_cyc),
    .tbl_up_dly_i(t_up), .tbl_blon_dly_i(t_blon), .tbl_bloff_dly_i(t_bloff),
    .tbl_down_dly_i(t_dn), .tbl_cycle_i(t_cyc), .rail_en_o(rail),
    .aux_ready_o(aux), .link_train_o(link), .video_en_o(video),
    .backlight_en_o(bl), .panel_on_o(pon), .seq_state_o(seq), .busy_o(busy),
    .cycle_active_o(cact), .timeout_o(tmo)
  );

  int cyc = 0, nvec = 0, nerr = 0;
  bit done_flag = 0;
  int rr, rf, ar, vr, vf, br, bf, cf;
  logic p_rail = 0, p_aux = 0, p_vid = 0, p_bl = 0, p_cyc = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rail && !p_rail)  rr = cyc;
    if (!rail && p_rail)  rf = cyc;
    if (aux && !p_aux)    ar = cyc;
    if (video && !p_vid)  vr = cyc;
    if (!video && p_vid)  vf = cyc;
    if (bl && !p_bl)      br = cyc;
    if (!bl && p_bl)      bf = cyc;
    if (!cact && p_cyc)   cf = cyc;
    p_rail = rail; p_aux = aux; p_vid = video; p_bl = bl; p_cyc = cact;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_win(string req, int meas, int n);
    int lo, hi;
    lo = (n > 0) ? (n - 1) * DIV : 0;
    hi = n * DIV + 4;
    nvec++;
    if (meas < lo || meas > hi) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, meas, lo, hi);
    end
  endtask

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic go_off();
    tgt = 1'b0;
    wait (cact);
    wait (!cact);
    step(2);
  endtask

  task automatic set_cfg(int u, int tu, int bo, int tbo, int bf_, int tbf, int d, int td, int c, int tc);
    c_up = 13'(u); t_up = 16'(tu); c_blon = 13'(bo); t_blon = 16'(tbo);
    c_bloff = 13'(bf_); t_bloff = 16'(tbf); c_dn = 13'(d); t_dn = 16'(td);
    c_cyc = 4'(c); t_cyc = 16'(tc);
    step(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int vals[3];
    int cr[3];
    int ct[3];
    int c0;
    vals = '{0, 3, 7};
    cr   = '{0, 1, 2};
    ct   = '{0, 3, 9};
    step(4);
    rst = 1'b0;
    step(1);
    // R12 reset state
    chk("R12 outputs after reset", {rail, aux, link, video, bl, pon, busy, cact, tmo, seq}, 0);

    // R1 R2 R3 R4 R5 R6 R8 sweep of register/table pairs
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        int a, b, e_up, e_on, e_off, e_dn, e_cy;
        a = vals[i]; b = vals[j];
        set_cfg(a, b, b, a, a, vals[(j+1)%3], vals[(i+2)%3], b, cr[i], ct[j]);
        e_up  = mx(a, b);
        e_on  = mx(b, a);
        e_off = mx(a, vals[(j+1)%3]);
        e_dn  = mx(vals[(i+2)%3], b);
        e_cy  = mx(cr[i] * SCALE, ct[j]);
        tgt = 1'b1;
        wait (bl);
        step(2);
        chk_win("R1/R6 rail to aux", ar - rr, e_up);
        chk_win("R2/R6 video to backlight", br - vr, e_on);
        chk("R8 enable order", int'(rr <= ar && ar < vr && vr < br), 1);
        chk("R10 on-idle status", {seq, pon, busy}, 6'b10_1_0 >> 0);
        go_off();
        chk_win("R3/R6 backlight off to video off", vf - bf, e_off);
        chk_win("R4/R6 video off to rail off", rf - vf, e_dn);
        chk_win("R5/R6 cycle window length", cf - rf, e_cy);
        chk("R8 disable order", int'(bf < vf && vf < rf), 1);
        chk("R9 no timeout on short power-down", tmo, 0);
        chk("R10 off-idle status", {seq, busy, rail}, 0);
      end
    end

    // R5 R10 re-power blocked during cycle window, status codes mid-sequence
    set_cfg(7, 0, 1, 0, 7, 0, 1, 0, 2, 0);
    tgt = 1'b1;
    wait (rail);
    step(1);
    chk("R10 powering-up code", {seq, busy}, 3'b01_1);
    wait (bl);
    tgt = 1'b0;
    wait (!bl);
    step(1);
    chk("R10 powering-down code", {seq, busy}, 3'b11_1);
    wait (cact);
    tgt = 1'b1;
    step(5);
    chk("R5 rail held off in window", {rail, cact}, 2'b01);
    chk("R10 window status", {seq, busy}, 3'b00_1);
    wait (rail);
    step(2);
    chk("R5 re-power waited for window", int'(rr - rf >= 11 * DIV), 1);
    wait (bl);
    go_off();

    // R2 backlight waits for training done
    set_cfg(1, 0, 1, 0, 1, 0, 1, 0, 0, 0);
    tdone = 1'b0;
    tgt = 1'b1;
    wait (video);
    step(60);
    chk("R2 backlight held until training done", {video, bl}, 2'b10);
    tdone = 1'b1;
    wait (bl);
    step(2);
    chk("R2 backlight after training done", bl, 1);
    go_off();

    // R7 force-rail
    set_cfg(7, 0, 1, 0, 1, 0, 1, 0, 1, 0);
    fvdd = 1'b1;
    wait (rail);
    step(1);
    chk("R7 aux waits after forced rail", {rail, aux, link}, 3'b100);
    wait (aux);
    step(2);
    chk_win("R7 forced rail to aux", ar - rr, 7);
    chk("R7 forced rail idle status", {seq, busy, video}, 0);
    tgt = 1'b1;
    c0 = cyc;
    wait (video);
    step(2);
    chk("R7 power-up skips up delay", int'(vr - c0 <= 6), 1);
    wait (bl);
    tgt = 1'b0;
    wait (!video);
    wait (!pon);
    step(3);
    chk("R7 rail and aux kept under force", {rail, aux, cact, video}, 4'b1100);
    fvdd = 1'b0;
    wait (cact);
    step(1);
    chk("R7 release opens window", {rail, aux, cact}, 3'b001);
    wait (!cact);
    step(2);

    // R11 target changes mid-sequence
    set_cfg(7, 0, 3, 0, 3, 0, 3, 0, 0, 0);
    tgt = 1'b1;
    wait (rail);
    step(3);
    tgt = 1'b0;
    wait (bl);
    step(1);
    chk("R11 power-up completes after drop", {bl, pon}, 2'b11);
    wait (cact);
    wait (!cact);
    step(2);
    chk("R11 pending off serviced", {rail, bl, seq}, 0);
    tgt = 1'b1;
    wait (bl);
    tgt = 1'b0;
    wait (!bl);
    step(1);
    tgt = 1'b1;
    wait (!rail);
    step(1);
    chk("R11 power-down completes after raise", cact, 1);
    wait (bl);
    step(1);
    chk("R11 pending on serviced", bl, 1);
    go_off();

    // R9 power-down timeout
    set_cfg(1, 0, 1, 0, 20, 0, 20, 0, 0, 0);
    tgt = 1'b1;
    wait (bl);
    go_off();
    chk("R9 timeout on long power-down", tmo, 1);
    tgt = 1'b1;
    wait (rail);
    step(1);
    chk("R9 timeout cleared by power-up", tmo, 0);
    wait (bl);
    go_off();

    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule